// File: doc/BRIEF.md
# Programmable-Rate Serial Character Transmitter

This block turns parallel characters into an asynchronous serial stream on a single output line. Software, or a neighbouring block, places a character in a one-entry holding register. When the shifter is idle, the character moves into it and goes out as a start bit, the data bits with the least significant bit first, an optional parity bit and one or more stop bits. The line rests at logic 1 between characters.

Timing comes from a 16-bit divisor. A divided tick runs at the clock rate over the divisor, and every serial bit lasts sixteen of those ticks. The line settings are static inputs that the shifter captures when it loads a character: character length, stop length, whether parity is sent and its sense. A separate break input overrides the line at once. Two flags report progress. One shows that the holding register can take a byte. The other shows that nothing at all is left to send.

Top module: `sertx_top`

## Requirements
- R1: After reset, and whenever nothing is being sent and break is off, `tx_out` is 1, and both `hold_empty` and `shift_empty` are 1.
- R2: A frame opens with one start bit at 0 and then sends the data bits least significant first. Each bit, the start bit included, lasts 16 ticks.
- R3: `char_len` values 2'b00, 2'b01, 2'b10 and 2'b11 send 5, 6, 7 and 8 data bits, taken from the low bits of the written byte.
- R4: With `parity_en`=1, a parity bit follows the data bits. With `parity_even`=1 it is the XOR of the sent data bits (even parity). With `parity_even`=0 it is the complement (odd parity). With `parity_en`=0 no parity bit is sent.
- R5: The stop period, at logic 1, is 16 ticks when `two_stop`=0. When `two_stop`=1 it is 24 ticks for 5-bit characters and 32 ticks for 6, 7 or 8-bit characters. `shift_empty` rises in the clock after the last stop tick.
- R6: One tick occurs every `divisor` clocks, so a bit lasts 16×`divisor` clocks. A divisor of 0 behaves as 1, and a change of divisor restarts the tick count.
- R7: While `force_break` is 1, `tx_out` is 0, whatever is being sent.
- R8: `hold_empty` falls in the clock after an accepted write. It rises again when the held byte moves into the shifter, which is also the clock in which the start bit begins.
- R9: `shift_empty` is 1 only when the holding register and the shifter are both empty.
- R10: A write while `hold_empty` is 0 is dropped: the held byte is kept and no extra frame is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| divisor | input | 16 | Clocks per tick; 0 acts as 1 |
| char_len | input | 2 | Character length code, 5 to 8 bits |
| two_stop | input | 1 | Long stop period select |
| parity_en | input | 1 | Send a parity bit |
| parity_even | input | 1 | 1 selects even parity, 0 odd |
| force_break | input | 1 | Hold the line at 0 |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to write |
| tx_out | output | 1 | Serial output line |
| hold_empty | output | 1 | Holding register can take a byte |
| shift_empty | output | 1 | Holding register and shifter both empty |

## Verification
Several rules are checked on every cycle. The line sits high whenever the shifter is drained and break is off. The shift-empty flag never rises while a byte is held. Holding-empty rises only together with a load. An accepted write clears holding-empty in the next clock. The first cycle of a frame drives a start bit. Ticks never come back to back once the divisor is 2 or more. The bench scenarios are needed for the rest: the order of bits, the parity value, the stop length in ticks, the bit time at a slow divisor, and the dropped write with its missing extra frame.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam int OVS = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [1:0] len;
    logic       two_stop;
    logic       par_en;
    logic       par_even;
  } line_cfg_t;

  function automatic int data_bits(input logic [1:0] code);
    return 5 + int'(code);
  endfunction

  function automatic int stop_ticks(input logic [1:0] code, input logic two);
    if (!two) return OVS;
    if (code == 2'b00) return OVS + OVS / 2;
    return 2 * OVS;
  endfunction

  function automatic logic par_bit(input logic [7:0] d, input logic [1:0] code,
                                   input logic even);
    logic [7:0] mask;
    mask = 8'hFF >> (3 - int'(code));
    return even ? ^(d & mask) : ~^(d & mask);
  endfunction

endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] prev_div;
  logic [DIV_W-1:0] div_eff;
  logic             div_chg;

  assign div_eff = (divisor == '0) ? DIV_W'(1) : divisor;
  assign div_chg = (divisor != prev_div);
  assign tick    = !div_chg && (cnt == div_eff - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      prev_div <= '0;
    end else begin
      prev_div <= divisor;
      if (div_chg || tick) cnt <= '0;
      else                 cnt <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (take) begin
      full <= 1'b0;
    end else if (wr_en && !full) begin
      full <= 1'b1;
      data <= wr_data;
    end
  end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  line_cfg_t     cfg,
  output logic          busy,
  output logic          line_bit
);
  localparam int SUB_W = $clog2(2 * OVS);
  localparam int IDX_W = $clog2(DW);

  tx_state_e        state;
  logic [SUB_W-1:0] sub;
  logic [SUB_W-1:0] last_sub;
  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    sh;
  line_cfg_t        cfg_q;
  logic             par_q;
  logic             phase_end;
  logic             last_data;

  assign busy     = (state != ST_IDLE);
  assign last_sub = (state == ST_STOP) ? SUB_W'(stop_ticks(cfg_q.len, cfg_q.two_stop) - 1)
                                       : SUB_W'(OVS - 1);
  assign phase_end = tick && (sub == last_sub);
  assign last_data = (idx == IDX_W'(data_bits(cfg_q.len) - 1));

  always_comb begin
    case (state)
      ST_START: line_bit = 1'b0;
      ST_DATA:  line_bit = sh[0];
      ST_PAR:   line_bit = par_q;
      default:  line_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      sub   <= '0;
      idx   <= '0;
      sh    <= '0;
      cfg_q <= '0;
      par_q <= 1'b0;
    end else if (load && state == ST_IDLE) begin
      state <= ST_START;
      sub   <= '0;
      idx   <= '0;
      sh    <= load_data;
      cfg_q <= cfg;
      par_q <= par_bit(load_data, cfg.len, cfg.par_even);
    end else if (busy && tick) begin
      if (!phase_end) begin
        sub <= sub + SUB_W'(1);
      end else begin
        sub <= '0;
        case (state)
          ST_START: state <= ST_DATA;
          ST_DATA: begin
            sh <= sh >> 1;
            if (last_data) begin
              idx   <= '0;
              state <= cfg_q.par_en ? ST_PAR : ST_STOP;
            end else begin
              idx <= idx + IDX_W'(1);
            end
          end
          ST_PAR:  state <= ST_STOP;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic [1:0]       char_len,
  input  logic             two_stop,
  input  logic             parity_en,
  input  logic             parity_even,
  input  logic             force_break,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  output logic             tx_out,
  output logic             hold_empty,
  output logic             shift_empty
);
  logic          baud_tick;
  logic          hold_full;
  logic [DW-1:0] hold_data;
  logic          shift_busy;
  logic          load_evt;
  logic          line_bit;
  line_cfg_t     cfg;

  assign cfg      = '{len: char_len, two_stop: two_stop, par_en: parity_en,
                      par_even: parity_even};
  assign load_evt = hold_full && !shift_busy;

  sertx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(baud_tick)
  );

  sertx_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .take(load_evt), .full(hold_full), .data(hold_data)
  );

  sertx_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .load(load_evt),
    .load_data(hold_data), .cfg(cfg), .busy(shift_busy), .line_bit(line_bit)
  );

  assign tx_out      = force_break ? 1'b0 : line_bit;
  assign hold_empty  = !hold_full;
  assign shift_empty = !hold_full && !shift_busy;
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] divisor,
  input logic             force_break,
  input logic             wr_en,
  input logic             tx_out,
  input logic             hold_empty,
  input logic             shift_empty,
  input logic             tick,
  input logic             load,
  input logic             busy
);
  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_empty && !force_break) |-> tx_out);

  // R9
  empty_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_empty |-> hold_empty);

  // R8
  hold_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_empty) |-> $past(load));

  // R8
  write_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_empty && wr_en) |=> !hold_empty);

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !force_break) |-> !tx_out);

  // R6
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && divisor > DIV_W'(1) && $stable(divisor)) |=> !tick);
endmodule

bind sertx_top sertx_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .divisor(divisor), .force_break(force_break),
  .wr_en(wr_en), .tx_out(tx_out), .hold_empty(hold_empty),
  .shift_empty(shift_empty), .tick(baud_tick), .load(load_evt), .busy(shift_busy)
);

// File: tb/sertx_top_tb.sv
module sertx_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] divisor = 16'd1;
  logic [1:0]  char_len = 2'b11;
  logic        two_stop = 1'b0;
  logic        parity_en = 1'b0;
  logic        parity_even = 1'b0;
  logic        force_break = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        tx_out, hold_empty, shift_empty;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  sertx_top u_dut (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .char_len(char_len),
    .two_stop(two_stop), .parity_en(parity_en), .parity_even(parity_even),
    .force_break(force_break), .wr_en(wr_en), .wr_data(wr_data),
    .tx_out(tx_out), .hold_empty(hold_empty), .shift_empty(shift_empty)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic set_line(input logic [1:0] l, input logic ts, input logic pe,
                          input logic pv);
    @(negedge clk);
    char_len = l; two_stop = ts; parity_en = pe; parity_even = pv;
  endtask

  task automatic wait_drain();
    while (shift_empty !== 1'b1) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Builds the expected frame: start, data LSB first, parity, one stop sample.
  function automatic int build(input logic [7:0] d, input logic [1:0] l,
                               input logic pe, input logic pv,
                               output logic [11:0] f);
    int nb = 5 + int'(l);
    int n = 0;
    logic x = 1'b0;
    f = '0;
    f[n] = 1'b0; n++;
    for (int i = 0; i < nb; i++) begin f[n] = d[i]; x ^= d[i]; n++; end
    if (pe) begin f[n] = pv ? x : ~x; n++; end
    f[n] = 1'b1; n++;
    return n;
  endfunction

  task automatic capture(input int nbits, input int bt, output logic [11:0] got);
    got = '0;
    while (tx_out !== 1'b0) @(negedge clk);
    repeat (bt / 2) @(negedge clk);
    got[0] = tx_out;
    for (int i = 1; i < nbits; i++) begin
      repeat (bt) @(negedge clk);
      got[i] = tx_out;
    end
  endtask

  task automatic frame_test(input string req, input logic [7:0] d, input int bt);
    logic [11:0] e, g;
    int n;
    n = build(d, char_len, parity_en, parity_even, e);
    wr(d);
    capture(n, bt, g);
    chk(g == e, req, int'(g), int'(e));
    wait_drain();
  endtask

  task automatic frame_len(input string req, input logic [7:0] d, input int exp);
    int n = 0;
    wr(d);
    while (tx_out !== 1'b0) @(negedge clk);
    while (shift_empty !== 1'b1) begin @(negedge clk); n++; end
    chk(n == exp, req, n, exp);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(tx_out === 1'b1, "R1 idle line", int'(tx_out), 1);
    chk(hold_empty === 1'b1, "R1 hold_empty reset", int'(hold_empty), 1);
    chk(shift_empty === 1'b1, "R1 shift_empty reset", int'(shift_empty), 1);
  endtask

  task automatic t_basic();
    set_line(2'b11, 1'b0, 1'b0, 1'b0);
    frame_test("R2 8N1 A5", 8'hA5, 16);
    frame_test("R2 8N1 3C", 8'h3C, 16);
  endtask

  task automatic t_lengths();
    set_line(2'b00, 1'b0, 1'b0, 1'b0); frame_test("R3 len5", 8'hF3, 16);
    set_line(2'b01, 1'b0, 1'b0, 1'b0); frame_test("R3 len6", 8'hEC, 16);
    set_line(2'b10, 1'b0, 1'b0, 1'b0); frame_test("R3 len7", 8'hD5, 16);
  endtask

  task automatic t_parity();
    set_line(2'b11, 1'b0, 1'b1, 1'b1); frame_test("R4 even 8", 8'h07, 16);
    set_line(2'b11, 1'b0, 1'b1, 1'b0); frame_test("R4 odd 8", 8'h07, 16);
    set_line(2'b00, 1'b0, 1'b1, 1'b0); frame_test("R4 odd 5 masked", 8'hE1, 16);
    set_line(2'b10, 1'b0, 1'b1, 1'b1); frame_test("R4 even 7", 8'h80, 16);
  endtask

  task automatic t_stop();
    set_line(2'b11, 1'b0, 1'b0, 1'b0); frame_len("R5 one stop", 8'h55, 16 * 9 + 16);
    set_line(2'b00, 1'b1, 1'b0, 1'b0); frame_len("R5 1.5 stop len5", 8'h15, 16 * 6 + 24);
    set_line(2'b01, 1'b1, 1'b1, 1'b1); frame_len("R5 two stop len6", 8'h2A, 16 * 8 + 32);
    set_line(2'b11, 1'b1, 1'b0, 1'b0); frame_len("R5 two stop len8", 8'hFF, 16 * 9 + 32);
  endtask

  task automatic t_divisor();
    int n = 0;
    set_line(2'b11, 1'b0, 1'b0, 1'b0);
    @(negedge clk); divisor = 16'd3;
    repeat (4) @(negedge clk);
    frame_test("R6 divisor 3 data", 8'h96, 48);
    wr(8'h00);
    while (tx_out !== 1'b0) @(negedge clk);
    while (shift_empty !== 1'b1) begin @(negedge clk); n++; end
    chk(n >= 3 * 160 - 2 && n <= 3 * 160, "R6 divisor 3 length", n, 480);
    repeat (3) @(negedge clk);
    @(negedge clk); divisor = 16'd0;
    repeat (2) @(negedge clk);
    frame_len("R6 divisor 0 as 1", 8'h81, 160);
    @(negedge clk); divisor = 16'd1;
  endtask

  task automatic t_break();
    logic seen_high = 1'b0;
    @(negedge clk); force_break = 1'b1;
    @(negedge clk);
    chk(tx_out === 1'b0, "R7 break idle", int'(tx_out), 0);
    wr(8'hFF);
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (tx_out !== 1'b0) seen_high = 1'b1;
    end
    chk(!seen_high, "R7 break during frame", int'(seen_high), 0);
    force_break = 1'b0;
    wait_drain();
    chk(tx_out === 1'b1, "R7 break released", int'(tx_out), 1);
  endtask

  task automatic t_flags();
    set_line(2'b11, 1'b0, 1'b0, 1'b0);
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h5A;
    @(negedge clk); wr_en = 1'b0;
    chk(hold_empty === 1'b0, "R8 cleared by write", int'(hold_empty), 0);
    chk(shift_empty === 1'b0, "R9 busy after write", int'(shift_empty), 0);
    @(negedge clk);
    chk(hold_empty === 1'b1, "R8 set on transfer", int'(hold_empty), 1);
    chk(tx_out === 1'b0, "R8 start with transfer", int'(tx_out), 0);
    chk(shift_empty === 1'b0, "R9 shifter still busy", int'(shift_empty), 0);
    wait_drain();
  endtask

  task automatic t_ignore();
    logic [11:0] e, g;
    int n;
    logic extra = 1'b0;
    set_line(2'b11, 1'b0, 1'b0, 1'b0);
    wr(8'h3C);
    while (hold_empty !== 1'b1) @(negedge clk);
    repeat (5) @(negedge clk);
    wr(8'hA2);
    wr(8'h5B);
    chk(hold_empty === 1'b0, "R10 held after dropped write", int'(hold_empty), 0);
    while (hold_empty !== 1'b1) @(negedge clk);
    n = build(8'hA2, 2'b11, 1'b0, 1'b0, e);
    capture(n, 16, g);
    chk(g == e, "R10 held byte kept", int'(g), int'(e));
    while (shift_empty !== 1'b1) @(negedge clk);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (tx_out !== 1'b1 || shift_empty !== 1'b1) extra = 1'b1;
    end
    chk(!extra, "R10 no extra frame", int'(extra), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_lengths();
    t_parity();
    t_stop();
    t_divisor();
    t_break();
    t_flags();
    t_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule